// File: doc/BRIEF.md
# Programmable-Increment System Time Counter

This block keeps a free-running 64-bit time value for packet timestamping. The time value advances by a programmable 24-bit step once in every programmable 8-bit number of clock ticks. Both settings sit in one increment attributes register. Software reads the time value as two read-only 32-bit words through a simple register port. A 64-bit output carries the live count to a capture unit.

Software first reads the low word. That read also snapshots the upper half of the counter, so a following high-word read returns the upper half that belongs to the low word just read. This holds even if a carry has moved the live counter into the next high value in between. A tick period of zero stops the counter.

Top module: `systime_counter`

## Requirements
- R1: After reset, the time value is zero. The increment attributes, the tick prescaler and the high-word snapshot are also zero, so all three registers read back 0.
- R2: The attributes register is at byte offset 0xB608. It holds the tick period in bits 31:24 and the step in bits 23:0. A write stores the whole word, and a read returns it unchanged.
- R3: With tick period P not equal to 0 and step S, the first advance after an attributes write comes on the P-th clock edge after the write edge. From then on, the counter adds S on every P-th edge. The `time_o` output shows the counter in the same cycle.
- R4: A tick period of 0 stops the counter. `time_o` holds its value for as long as the period stays 0.
- R5: An attributes write clears the tick prescaler on its write edge, and no advance happens on that edge. A rewrite in the middle of a period therefore delays the next advance to P edges after the rewrite.
- R6: A read at byte offset 0xB600 returns the low 32 bits of the counter value held just before the read edge. On the same edge, the high 32 bits of that value are stored as the snapshot. If an advance on the read edge carries into the high half, the returned pair still belongs to the value before the edge.
- R7: A read at byte offset 0xB604 returns the stored snapshot, not the live high half. A high read with no new low read before it returns the last snapshot again.
- R8: Writes to 0xB600 or 0xB604 have no effect. The counter keeps its normal progression.
- R9: Read data appears on `reg_rdata` in the cycle after the read strobe and holds until the next read. A read of any unmapped offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_addr | input | ADDR_W (16) | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| time_o | output | 64 | Live 64-bit time value for the capture unit |

## Verification
Two events can land on the same clock edge: a low-word read that snapshots the high half, and an advance that carries out of the low word. The bench sets a step of 0xFFFFFF with a period of 1 and times a low-word read for the edge at which the counter crosses 2^32. It then judges the result in three ways: the low word must be 0xFFFFFF00, the following high read must return 0, and `time_o` must already show 1 in its high half. An attributes rewrite in the middle of a period is checked the same way. It is placed where the old prescaler phase would have fired on the next edge, and `time_o` must stay still until P edges after the rewrite.

// File: rtl/systime_pkg.sv
package systime_pkg;
  localparam int TIME_W   = 64;
  localparam int WORD_W   = 32;
  localparam int PERIOD_W = 8;
  localparam int STEP_W   = 24;

  typedef struct packed {
    logic [PERIOD_W-1:0] period;
    logic [STEP_W-1:0]   step;
  } incr_attr_t;
endpackage

// File: rtl/systime_rst_sync.sv
module systime_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_async_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_async_n) begin
    if (!rst_async_n) sync_q <= '0;
    else              sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/systime_prescaler.sv
module systime_prescaler
  import systime_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic                restart_i,
  output logic                fire_o
);
  logic [PERIOD_W-1:0] cnt_q, cnt_d;
  logic                cnt_en;
  logic                at_end;

  assign at_end = (period_i != '0) && (cnt_q >= period_i - PERIOD_W'(1));

  always_comb begin
    fire_o = 1'b0;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (restart_i) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (period_i == '0) begin
      cnt_d  = '0;
      cnt_en = (cnt_q != '0);
    end else if (at_end) begin
      fire_o = 1'b1;
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else begin
      cnt_d  = cnt_q + PERIOD_W'(1);
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R4
  halt_no_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (period_i == '0) |-> !fire_o);

  // R5
  restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (cnt_q == '0));
endmodule

// File: rtl/systime_accum.sv
module systime_accum
  import systime_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire_i,
  input  logic [STEP_W-1:0] step_i,
  output logic [TIME_W-1:0] time_o
);
  logic [TIME_W-1:0] time_q, time_d;

  always_comb begin
    time_d = time_q + TIME_W'(step_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      time_q <= '0;
    else if (fire_i) time_q <= time_d;
  end

  assign time_o = time_q;

  // R3
  advance_by_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_i |=> (time_q == $past(time_q) + TIME_W'($past(step_i))));

  // R4
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fire_i |=> $stable(time_q));
endmodule

// File: rtl/systime_regif.sv
module systime_regif
  import systime_pkg::*;
#(
  parameter int              ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] OFS_LO   = 16'hB600,
  parameter logic [ADDR_W-1:0] OFS_HI   = 16'hB604,
  parameter logic [ADDR_W-1:0] OFS_ATTR = 16'hB608
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [TIME_W-1:0] time_i,
  output incr_attr_t        attr_o,
  output logic              restart_o,
  output logic [WORD_W-1:0] rdata_o
);
  incr_attr_t        attr_q;
  logic [WORD_W-1:0] snap_q, rdata_q, rdata_d;
  logic              sel_lo, sel_hi, sel_attr;
  logic              attr_we, snap_en;

  assign sel_lo   = (addr_i == OFS_LO);
  assign sel_hi   = (addr_i == OFS_HI);
  assign sel_attr = (addr_i == OFS_ATTR);
  assign attr_we  = wr_i && sel_attr;
  assign snap_en  = rd_i && sel_lo;

  always_comb begin
    rdata_d = '0;
    if (sel_lo)        rdata_d = time_i[WORD_W-1:0];
    else if (sel_hi)   rdata_d = snap_q;
    else if (sel_attr) rdata_d = attr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       attr_q <= '0;
    else if (attr_we) attr_q <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       snap_q <= '0;
    else if (snap_en) snap_q <= time_i[TIME_W-1:WORD_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdata_q <= '0;
    else if (rd_i) rdata_q <= rdata_d;
  end

  assign attr_o    = attr_q;
  assign restart_o = attr_we;
  assign rdata_o   = rdata_q;

  // R2
  attr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    attr_we |=> (attr_o == $past(wdata_i)));

  // R6
  low_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snap_en |=> (rdata_o == $past(time_i[WORD_W-1:0])));

  // R7
  high_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_en |=> $stable(snap_q));
endmodule

// File: rtl/systime_counter.sv
module systime_counter
  import systime_pkg::*;
#(
  parameter int              ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] OFS_LO   = 16'hB600,
  parameter logic [ADDR_W-1:0] OFS_HI   = 16'hB604,
  parameter logic [ADDR_W-1:0] OFS_ATTR = 16'hB608,
  parameter int              SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [63:0]       time_o
);
  logic       rst_int_n;
  incr_attr_t attr;
  logic       restart;
  logic       fire;

  systime_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk         (clk),
    .rst_async_n (rst_n),
    .rst_sync_n  (rst_int_n)
  );

  systime_regif #(
    .ADDR_W   (ADDR_W),
    .OFS_LO   (OFS_LO),
    .OFS_HI   (OFS_HI),
    .OFS_ATTR (OFS_ATTR)
  ) i_regif (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .addr_i    (reg_addr),
    .wr_i      (reg_wr),
    .rd_i      (reg_rd),
    .wdata_i   (reg_wdata),
    .time_i    (time_o),
    .attr_o    (attr),
    .restart_o (restart),
    .rdata_o   (reg_rdata)
  );

  systime_prescaler i_prescaler (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .period_i  (attr.period),
    .restart_i (restart),
    .fire_o    (fire)
  );

  systime_accum i_accum (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .fire_i (fire),
    .step_i (attr.step),
    .time_o (time_o)
  );
endmodule

// File: tb/test_systime_counter.sv
module test_systime_counter;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] A_LO   = 16'hB600;
  localparam logic [15:0] A_HI   = 16'hB604;
  localparam logic [15:0] A_ATTR = 16'hB608;

  logic        clk;
  logic        rst_n;
  logic [15:0] reg_addr;
  logic        reg_wr;
  logic        reg_rd;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [63:0] time_o;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  systime_counter i_systime_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .time_o    (time_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; reg_addr = '0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic write_reg(input logic [15:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic read_reg(input logic [15:0] a, output logic [31:0] d);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    d = reg_rdata;
    reg_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] attr_word(input int p, input logic [23:0] s);
    return {8'(p), s};
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    check("R1 time after reset", time_o, 64'd0);
    read_reg(A_ATTR, d); check("R1 attr after reset", {32'd0, d}, 64'd0);
    read_reg(A_HI, d);   check("R1 snapshot after reset", {32'd0, d}, 64'd0);
    idle(5);
    check("R1 no advance with zero attr", time_o, 64'd0);
  endtask

  task automatic t_attr_rw();
    logic [31:0] d;
    write_reg(A_ATTR, 32'h00ABCDEF);
    read_reg(A_ATTR, d); check("R2 attr readback", {32'd0, d}, 64'h00ABCDEF);
    read_reg(16'hB60C, d); check("R9 unmapped read", {32'd0, d}, 64'd0);
    read_reg(16'h0000, d); check("R9 unmapped read low offset", {32'd0, d}, 64'd0);
  endtask

  task automatic t_rate(input int p, input logic [23:0] s, input int n);
    logic [63:0] base;
    write_reg(A_ATTR, attr_word(p, s));
    base = time_o;
    idle(n);
    check($sformatf("R3 period %0d step %h after %0d", p, s, n), time_o,
          base + 64'(n / p) * 64'(s));
  endtask

  task automatic t_halt();
    logic [63:0] base;
    write_reg(A_ATTR, attr_word(0, 24'h000123));
    base = time_o;
    idle(20);
    check("R4 period zero holds", time_o, base);
  endtask

  task automatic t_restart();
    logic [63:0] base;
    write_reg(A_ATTR, attr_word(4, 24'd100));
    idle(2);
    write_reg(A_ATTR, attr_word(4, 24'd100));
    base = time_o;
    idle(3);
    check("R5 no advance before period after rewrite", time_o, base);
    idle(1);
    check("R5 advance at period after rewrite", time_o, base + 64'd100);
  endtask

  task automatic t_ro_words();
    logic [63:0] base;
    write_reg(A_ATTR, attr_word(1, 24'd7));
    base = time_o;
    idle(2);
    write_reg(A_LO, 32'hFFFF_FFFF);
    check("R8 write to low word ignored", time_o, base + 64'd21);
    write_reg(A_HI, 32'h1234_5678);
    check("R8 write to high word ignored", time_o, base + 64'd28);
  endtask

  task automatic t_snapshot();
    logic [31:0] lo, hi;
    logic [63:0] v;
    do_reset();
    write_reg(A_ATTR, attr_word(1, 24'hFFFFFF));
    idle(599);
    v = 64'd599 * 64'hFFFFFF;
    read_reg(A_LO, lo);
    check("R6 low word value", {32'd0, lo}, {32'd0, v[31:0]});
    idle(300);
    read_reg(A_HI, hi);
    check("R7 high returns snapshot not live", {32'd0, hi}, {32'd0, v[63:32]});
    check("R7 live high has moved", {32'd0, time_o[63:32]}, 64'd3);
    read_reg(A_HI, hi);
    check("R7 repeat high read keeps snapshot", {32'd0, hi}, {32'd0, v[63:32]});
    v = time_o;
    read_reg(A_LO, lo);
    read_reg(A_HI, hi);
    check("R6 fresh pair matches time_o", {hi, lo}, v);
  endtask

  task automatic t_carry();
    logic [31:0] lo, hi;
    do_reset();
    write_reg(A_ATTR, attr_word(1, 24'hFFFFFF));
    idle(256);
    read_reg(A_LO, lo);
    check("R6 low at carry edge", {32'd0, lo}, 64'h0000_0000_FFFF_FF00);
    check("R6 counter advanced on read edge", time_o, 64'd257 * 64'hFFFFFF);
    read_reg(A_HI, hi);
    check("R6 high snapshot before carry", {32'd0, hi}, 64'd0);
    check("R6 live high after carry", {32'd0, time_o[63:32]}, 64'd1);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    t_reset();
    t_attr_rw();
    t_rate(1, 24'd40 << 18, 9);
    t_rate(3, 24'd125 << 17, 7);
    t_rate(5, 24'h000031, 23);
    t_rate(2, 24'hFFFFFF, 10);
    t_halt();
    t_restart();
    t_ro_words();
    t_snapshot();
    t_carry();
    done = 1;
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end
endmodule